// File: doc/BRIEF.md
# Multi-Port Wake Edge Monitor

This block watches a bank of general-purpose input pins, grouped as four ports of eight, together with one extra line from a USB transceiver. It records when a chosen edge appears on any of them, so that a sleeping system can be woken. Each pin has two settings, both held in 32-bit words: which edge it reacts to, and whether it takes part at all. A pin's bit lives at index port*8+pin in every one of these words.

Every input passes through a two-stage synchronizer before edge detection. A qualifying edge sets a sticky bit in the detect word. Software reads that word and clears bits by writing ones to them. A second read-only word shows the detect bits ANDed with the enables. The USB line has its own edge-select bit and its own sticky detect bit. The single wake request is the OR of every masked detect bit and the USB detect bit. The USB channel has no enable of its own, so it is always armed.

Register access is a plain single-cycle port. A write takes effect at the clock edge where it is presented. Reads are combinational on the offset.

Top module: `wake_edge_monitor`

## Requirements
- R1: While reset is low and right after it, every register reads 0 and `wake_o` is low.
- R2: Input `pin_i[k]` is controlled and reported at bit k of each 32-bit word, where k = port*8+pin.
- R3: At offset 0x704, bit k set to 0 makes pin k react to rising edges, and set to 1 makes it react to falling edges. The opposite edge leaves the detect bit at 0.
- R4: At offset 0x710, bit k set to 1 arms pin k. A disarmed pin never sets its detect bit, whatever edges it sees.
- R5: At offset 0x718, the detect bits stay set until cleared. Writing a 1 clears that bit, and writing a 0 leaves the bit unchanged.
- R6: If an edge event and a clearing write hit the same detect bit in the same cycle, the bit ends up set. Other bits in the same write are still cleared.
- R7: Offset 0x720 reads the detect word ANDed with the enable word. Clearing an enable bit hides the bit there but leaves it set in the raw word at 0x718.
- R8: Bit 0 of offset 0x708 selects the USB edge (0 rising, 1 falling). Bit 0 of offset 0x71C is the USB detect bit, which is set by that edge and cleared by writing 1.
- R9: `wake_o` is high exactly when the masked word at 0x720 is non-zero or the USB detect bit is set.
- R10: A qualifying input change made between two clock edges shows in the detect bit after the third following rising edge, and not earlier.
- R11: Reads of any offset not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Port pins, index port*8+pin |
| usb_i | input | 1 | USB wake line |
| reg_wr_i | input | 1 | Write strobe |
| reg_addr_i | input | 12 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| wake_o | output | 1 | Wake request |

## Verification
The bench sweeps every pin under both edge settings. For each one it first applies the wrong edge and then the right one, which exposes a swapped polarity, a bit landing at the wrong index, or an event leaking into a neighbouring pin. It times a single edge to land in the same cycle as a clearing write to the same bit. A design where the clear wins would lose that event, and one that ignored the write would keep a second, unrelated bit set. It also removes an enable after a detection: the masked view and `wake_o` must drop while the raw word keeps the bit, and a design that cleared the sticky bit would fail there. The exact latency is sampled cycle by cycle, so a missing or extra synchronizer stage shows up at once.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_EDGE     = 12'h704;
  localparam logic [ADDR_W-1:0] OFS_USB_EDGE = 12'h708;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 12'h710;
  localparam logic [ADDR_W-1:0] OFS_DETECT   = 12'h718;
  localparam logic [ADDR_W-1:0] OFS_USB_DET  = 12'h71C;
  localparam logic [ADDR_W-1:0] OFS_MASKED   = 12'h720;

  // fall=0: low-to-high counts; fall=1: high-to-low counts
  function automatic logic edge_seen(logic prev, logic cur, logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction

  // set has priority over clear
  function automatic logic sticky_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_edge_bank.sv
module wake_edge_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit_o[i] = wake_pkg::edge_seen(prev_q[i], level_i[i], fall_i[i]);
  end
endmodule

// File: rtl/wake_sticky.sv
module wake_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= wake_pkg::sticky_next(q_o[i], set_i[i], clr_i[i]);
    end
  end
endmodule

// File: rtl/wake_edge_monitor.sv
module wake_edge_monitor #(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] pin_i,
  input  logic                        usb_i,
  input  logic                        reg_wr_i,
  input  logic [wake_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic [wake_pkg::REG_W-1:0]  reg_wdata_i,
  output logic [wake_pkg::REG_W-1:0]  reg_rdata_o,
  output logic                        wake_o
);
  import wake_pkg::*;

  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  // configuration
  logic [NUM_PINS-1:0] fall_sel_q;
  logic [NUM_PINS-1:0] en_q;
  logic                usb_fall_q;

  // named internal events
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_hit;
  logic [NUM_PINS-1:0] set_evt;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] det_q;
  logic [NUM_PINS-1:0] masked;
  logic                usb_sync;
  logic                usb_hit;
  logic                usb_set;
  logic                usb_clr;
  logic                usb_det_q;

  logic wr_edge, wr_usb_edge, wr_enable, wr_detect, wr_usb_det;

  assign wr_edge     = reg_wr_i && (reg_addr_i == OFS_EDGE);
  assign wr_usb_edge = reg_wr_i && (reg_addr_i == OFS_USB_EDGE);
  assign wr_enable   = reg_wr_i && (reg_addr_i == OFS_ENABLE);
  assign wr_detect   = reg_wr_i && (reg_addr_i == OFS_DETECT);
  assign wr_usb_det  = reg_wr_i && (reg_addr_i == OFS_USB_DET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_sel_q <= '0;
      en_q       <= '0;
      usb_fall_q <= 1'b0;
    end else begin
      if (wr_edge)     fall_sel_q <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_enable)   en_q       <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_usb_edge) usb_fall_q <= reg_wdata_i[0];
    end
  end

  // pin path
  wake_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  wake_edge_bank #(.W(NUM_PINS)) u_pin_edge (
    .clk(clk), .rst_n(rst_n), .level_i(pin_sync), .fall_i(fall_sel_q), .hit_o(pin_hit)
  );

  assign set_evt  = pin_hit & en_q;
  assign clr_mask = wr_detect ? reg_wdata_i[NUM_PINS-1:0] : '0;

  wake_sticky #(.W(NUM_PINS)) u_pin_det (
    .clk(clk), .rst_n(rst_n), .set_i(set_evt), .clr_i(clr_mask), .q_o(det_q)
  );

  // USB path
  wake_sync #(.W(1), .STAGES(SYNC_STAGES)) u_usb_sync (
    .clk(clk), .rst_n(rst_n), .d_i(usb_i), .q_o(usb_sync)
  );

  wake_edge_bank #(.W(1)) u_usb_edge (
    .clk(clk), .rst_n(rst_n), .level_i(usb_sync), .fall_i(usb_fall_q), .hit_o(usb_hit)
  );

  assign usb_set = usb_hit;
  assign usb_clr = wr_usb_det & reg_wdata_i[0];

  wake_sticky #(.W(1)) u_usb_det (
    .clk(clk), .rst_n(rst_n), .set_i(usb_set), .clr_i(usb_clr), .q_o(usb_det_q)
  );

  // views and wake
  assign masked = det_q & en_q;
  assign wake_o = (|masked) | usb_det_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_EDGE:     reg_rdata_o[NUM_PINS-1:0] = fall_sel_q;
      OFS_ENABLE:   reg_rdata_o[NUM_PINS-1:0] = en_q;
      OFS_DETECT:   reg_rdata_o[NUM_PINS-1:0] = det_q;
      OFS_MASKED:   reg_rdata_o[NUM_PINS-1:0] = masked;
      OFS_USB_EDGE: reg_rdata_o[0] = usb_fall_q;
      OFS_USB_DET:  reg_rdata_o[0] = usb_det_q;
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wake_edge_monitor_chk.sv
module wake_edge_monitor_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [W-1:0] det,
  input logic [W-1:0] en,
  input logic [W-1:0] set_evt,
  input logic [W-1:0] clr_mask,
  input logic         usb_set,
  input logic         usb_det,
  input logic         wake
);
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (det == '0 && !usb_det && !wake)); // R1

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((det & ~$past(det) & ~$past(en)) == '0)); // R4

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((det & ~$past(det) & ~$past(set_evt)) == '0)); // R5

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_evt)) |=> ((det & $past(clr_mask & ~set_evt)) == '0)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt & clr_mask)) |=>
      ((det & $past(set_evt & clr_mask)) == $past(set_evt & clr_mask))); // R6

  AST_USB_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_det) |-> $past(usb_set)); // R8

  AST_WAKE_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake) |-> $past(reg_wr)); // R9
endmodule

bind wake_edge_monitor wake_edge_monitor_chk #(.W(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr_i), .det(det_q), .en(en_q),
  .set_evt(set_evt), .clr_mask(clr_mask), .usb_set(usb_set),
  .usb_det(usb_det_q), .wake(wake_o)
);

// File: tb/wake_edge_monitor_test.sv
module wake_edge_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 32;
  localparam int SYNC       = 2;
  localparam logic [11:0] A_EDGE = 12'h704, A_USBE = 12'h708, A_EN = 12'h710,
                          A_DET = 12'h718, A_USBD = 12'h71C, A_MASK = 12'h720;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPINS-1:0] pins = '0;
  logic usb = 1'b0;
  logic wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic wake;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_edge_monitor uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .usb_i(usb), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rreg(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wake in reset", {31'b0, wake}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg("R1 edge", A_EDGE, 0);
    expect_reg("R1 enable", A_EN, 0);
    expect_reg("R1 detect", A_DET, 0);
    expect_reg("R1 masked", A_MASK, 0);
    expect_reg("R1 usb edge", A_USBE, 0);
    expect_reg("R1 usb det", A_USBD, 0);
    check("R1 wake", {31'b0, wake}, 0);
    expect_reg("R11 unmapped", 12'h714, 0);

    // R4: disarmed pin never detects
    pins[5] = 1'b1; settle(); pins[5] = 1'b0; settle();
    expect_reg("R4 disarmed", A_DET, 0);

    // R2/R3 sweep: every pin, both polarities, wrong edge then right edge
    for (int p = 0; p < NPINS; p++) begin
      for (int f = 0; f < 2; f++) begin
        wreg(A_EN, 0);
        pins[p] = (f == 0);
        settle();
        wreg(A_EDGE, 32'(f) << p);
        wreg(A_EN, 32'h1 << p);
        pins[p] = ~pins[p];   // wrong edge
        settle();
        expect_reg($sformatf("R3 wrong edge p%0d f%0d", p, f), A_DET, 0);
        pins[p] = ~pins[p];   // selected edge
        settle();
        expect_reg($sformatf("R2 detect p%0d f%0d", p, f), A_DET, 32'h1 << p);
        check($sformatf("R9 wake p%0d", p), {31'b0, wake}, 1);
        wreg(A_DET, 32'h1 << p);
        expect_reg($sformatf("R5 cleared p%0d", p), A_DET, 0);
      end
      pins[p] = 1'b0;
    end
    wreg(A_EN, 0); settle();

    // R7: multi-pin pattern, masked view
    pat = 32'hA5A5_0F0F;
    wreg(A_EDGE, 0);
    wreg(A_EN, 32'hFFFF_FFFF);
    pins = pat; settle();
    expect_reg("R2 pattern", A_DET, pat);
    wreg(A_EN, 32'hFFFF_0000);
    expect_reg("R7 masked half", A_MASK, pat & 32'hFFFF_0000);
    expect_reg("R7 raw kept", A_DET, pat);
    check("R9 wake partial", {31'b0, wake}, 1);
    wreg(A_EN, 0);
    expect_reg("R7 masked none", A_MASK, 0);
    expect_reg("R7 raw still", A_DET, pat);
    check("R9 wake off", {31'b0, wake}, 0);

    // R5: write zero no effect, partial clear
    wreg(A_DET, 0);
    expect_reg("R5 zero write", A_DET, pat);
    wreg(A_DET, 32'h0000_0F00);
    expect_reg("R5 partial", A_DET, pat & ~32'h0000_0F00);
    wreg(A_DET, 32'hFFFF_FFFF);
    expect_reg("R5 all", A_DET, 0);
    pins = '0; settle();

    // R10: latency
    wreg(A_EN, 32'h0000_0040);
    pins[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    expect_reg("R10 two edges", A_DET, 0);
    @(negedge clk);
    expect_reg("R10 third edge", A_DET, 32'h40);
    wreg(A_DET, 32'h40);

    // R6: set and clear same cycle
    wreg(A_EN, 32'h18);
    pins[4] = 1'b1; settle();
    expect_reg("R6 setup", A_DET, 32'h10);
    pins[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    wreg(A_DET, 32'h18);
    expect_reg("R6 set wins", A_DET, 32'h08);
    wreg(A_DET, 32'hFFFF_FFFF);
    wreg(A_EN, 0);
    pins = '0; settle();

    // R8: USB rising then falling
    usb = 1'b1; settle();
    expect_reg("R8 usb rise", A_USBD, 1);
    check("R9 usb wake", {31'b0, wake}, 1);
    wreg(A_USBD, 0);
    expect_reg("R8 usb zero write", A_USBD, 1);
    wreg(A_USBD, 1);
    expect_reg("R8 usb clear", A_USBD, 0);
    check("R9 usb wake gone", {31'b0, wake}, 0);
    wreg(A_USBE, 1);
    expect_reg("R8 usb edge reg", A_USBE, 1);
    usb = 1'b0; settle();
    expect_reg("R8 usb fall", A_USBD, 1);
    usb = 1'b1; settle();
    wreg(A_USBD, 1);
    expect_reg("R8 usb rise ignored", A_USBD, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule